// File: doc/BRIEF.md
# RTC Release and Access-Window Controller

This block is the gatekeeper in front of a real-time-clock peripheral's register set. After power-on it keeps the peripheral held in its reset state. Software releases it by writing one fixed 32-bit release word to the release register. Once released, the peripheral stays released until the next power-on reset, whatever software writes afterwards.

After the release, a 16-bit key written to the key register opens an access window. The window lasts a fixed number of slow RTC clocks (`WINDOW_LEN`, 1024 by default) and then closes by itself. While the window is open, `access_en` is high. Neighbouring register blocks use it to gate their writes and read-back. The block has one clock, a simple register write/read port and two status outputs.

Two state machines do the work. The release machine has the states HELD and RUNNING. Its only transition, HELD to RUNNING, is taken on a write of the release word. The window machine has the states CLOSED and OPEN. It goes from CLOSED to OPEN on a key write while RUNNING. It stays in OPEN with a reloaded count on a repeated key write, and goes from OPEN to CLOSED when the count runs out.

Top module: `rtc_gate_ctrl`

## Requirements
- R1: After reset `active` and `access_en` are 0, and both registers read as 0.
- R2: A write of 0xA5EB1357 to the release register (offset 0x0) sets `active` from the next cycle on, and bit 0 of that register then reads 1.
- R3: Any other value written to the release register, or the release word written to another offset, leaves `active` at 0. Once `active` is 1 it stays 1 whatever is written later.
- R4: Bits 31:1 of the release register always read 0.
- R5: While `active` is 1, a write to the key register (offset 0x4) whose bits 15:0 are 0xA965 sets `access_en` from the next cycle on. Bits 31:16 of the written data are ignored.
- R6: After it is set, `access_en` stays 1 for exactly `WINDOW_LEN` cycles and then clears without any further write.
- R7: A key write while the window is open restarts the count, so the window then lasts `WINDOW_LEN` cycles from that write.
- R8: Key writes made while `active` is 0 are ignored: `access_en` stays 0, also after a later release.
- R9: A write of any other value to the key register neither opens a window nor closes or shortens an open one.
- R10: The key register reads `access_en` at bit 16; its bits 15:0 and all other bits read 0.
- R11: Reads of offsets other than 0x0 and 0x4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow RTC clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W (4) | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| active | output | 1 | Peripheral released from reset |
| access_en | output | 1 | Register-access window open |

## Verification
The bench measures the window length cycle by cycle. An off-by-one in the expiry count would show up as 1023 or 1025 high cycles. A design that ignored a repeated key would close early, and one that treated a wrong key as a close would cut the window short. Key writes are issued before the release, because a design that latched them would open a window as soon as it was released. Near-miss release words, the release word written at the wrong offset, and later overwrites with zero check that the release cannot be faked or undone.

// File: rtl/rtc_gate_pkg.sv
package rtc_gate_pkg;

    typedef enum logic {
        REL_HELD    = 1'b0,
        REL_RUNNING = 1'b1
    } rel_state_t;

    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_t;

endpackage

// File: rtl/rtc_gate_decode.sv
module rtc_gate_decode #(
    parameter int                 ADDR_W   = 4,
    parameter logic [ADDR_W-1:0]  INIT_OFS = 4'h0,
    parameter logic [ADDR_W-1:0]  KEY_OFS  = 4'h4,
    parameter logic [31:0]        MAGIC    = 32'hA5EB_1357,
    parameter logic [15:0]        PASSWORD = 16'hA965
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              magic_hit,
    output logic              key_hit
);

    always_comb begin
        magic_hit = wr_en && (addr == INIT_OFS) && (wdata == MAGIC);
        key_hit   = wr_en && (addr == KEY_OFS) && (wdata[15:0] == PASSWORD);
    end

endmodule

// File: rtl/rtc_release_fsm.sv
module rtc_release_fsm
    import rtc_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic magic_hit,
    output logic active
);

    rel_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REL_HELD:    if (magic_hit) state_d = REL_RUNNING;
            REL_RUNNING: state_d = REL_RUNNING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REL_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            REL_HELD:    active = 1'b0;
            REL_RUNNING: active = 1'b1;
        endcase
    end

    // R3: release is permanent
    a_r3_stays_active: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> active);

    // R2: release only follows a release-word write
    a_r2_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !active && !magic_hit |=> !active);

endmodule

// File: rtl/rtc_window_fsm.sv
module rtc_window_fsm
    import rtc_gate_pkg::*;
#(
    parameter int WINDOW_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic key_hit,
    output logic access_en
);

    localparam int CNT_W = (WINDOW_LEN > 1) ? $clog2(WINDOW_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_LEN - 1);

    win_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             open_req;

    assign open_req = key_hit && active;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_CLOSED: if (open_req) state_d = WIN_OPEN;
            WIN_OPEN:   if (!open_req && cnt_q == '0) state_d = WIN_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_CLOSED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (open_req)                     cnt_q <= LAST;
        else if (state_q == WIN_OPEN && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        unique case (state_q)
            WIN_CLOSED: access_en = 1'b0;
            WIN_OPEN:   access_en = 1'b1;
        endcase
    end

    // R8: no window before release
    a_r8_closed_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !access_en);

    // R5: a window only opens on a valid key while released
    a_r5_open_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !access_en && !(key_hit && active) |=> !access_en);

    // R6: window closes when the count is spent and no key arrives
    a_r6_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        access_en && cnt_q == '0 && !key_hit |=> !access_en);

    // R7: a key inside the window keeps it open with a full count
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        access_en && key_hit |=> access_en && cnt_q == LAST);

endmodule

// File: rtl/rtc_gate_ctrl.sv
module rtc_gate_ctrl #(
    parameter int                 ADDR_W     = 4,
    parameter logic [ADDR_W-1:0]  INIT_OFS   = 4'h0,
    parameter logic [ADDR_W-1:0]  KEY_OFS    = 4'h4,
    parameter logic [31:0]        MAGIC      = 32'hA5EB_1357,
    parameter logic [15:0]        PASSWORD   = 16'hA965,
    parameter int                 WINDOW_LEN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              active,
    output logic              access_en
);

    localparam int FLAG_BIT = 16;

    logic magic_hit;
    logic key_hit;

    rtc_gate_decode #(
        .ADDR_W  (ADDR_W),
        .INIT_OFS(INIT_OFS),
        .KEY_OFS (KEY_OFS),
        .MAGIC   (MAGIC),
        .PASSWORD(PASSWORD)
    ) u_decode (
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .magic_hit(magic_hit),
        .key_hit  (key_hit)
    );

    rtc_release_fsm u_release (
        .clk      (clk),
        .rst_n    (rst_n),
        .magic_hit(magic_hit),
        .active   (active)
    );

    rtc_window_fsm #(
        .WINDOW_LEN(WINDOW_LEN)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .key_hit  (key_hit),
        .access_en(access_en)
    );

    always_comb begin
        rdata = '0;
        if (addr == INIT_OFS)     rdata[0]        = active;
        else if (addr == KEY_OFS) rdata[FLAG_BIT] = access_en;
    end

    // R4: write-only part of the release register never reads back
    a_r4_init_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        addr == INIT_OFS |-> rdata[31:1] == '0);

    // R10: key field never reads back
    a_r10_key_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        addr == KEY_OFS |-> rdata[15:0] == '0);

endmodule

// File: tb/rtc_gate_ctrl_tb_top.sv
module rtc_gate_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 1024;
    localparam logic [3:0] A_INIT = 4'h0;
    localparam logic [3:0] A_KEY  = 4'h4;
    localparam logic [3:0] A_OTHER = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        active;
    logic        access_en;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_gate_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .active   (active),
        .access_en(access_en)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail   = n_fail + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // number of cycles access_en stays high, counting the current one
    task automatic remaining(output int n);
        n = 0;
        while (access_en && n < 4 * WIN) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        check("R1 active", {31'b0, active}, 32'd0);
        check("R1 access_en", {31'b0, access_en}, 32'd0);
        rd(A_INIT, d); check("R1 init read", d, 32'd0);
        rd(A_KEY, d);  check("R1 key read", d, 32'd0);
    endtask

    task automatic t_key_before_release();
        wr(A_KEY, 32'h0000_A965);
        check("R8 key ignored while held", {31'b0, access_en}, 32'd0);
        idle(3);
        check("R8 still closed", {31'b0, access_en}, 32'd0);
    endtask

    task automatic t_bad_release();
        logic [31:0] d;
        wr(A_INIT, 32'hA5EB_1356);
        check("R3 near-miss word", {31'b0, active}, 32'd0);
        wr(A_INIT, 32'h25EB_1357);
        check("R3 top-bit miss", {31'b0, active}, 32'd0);
        wr(A_KEY, 32'hA5EB_1357);
        check("R3 word at key offset", {31'b0, active}, 32'd0);
        wr(A_OTHER, 32'hA5EB_1357);
        check("R11 word at other offset", {31'b0, active}, 32'd0);
        rd(A_OTHER, d); check("R11 other read", d, 32'd0);
    endtask

    task automatic t_release();
        logic [31:0] d;
        wr(A_INIT, 32'hA5EB_1357);
        check("R2 active set", {31'b0, active}, 32'd1);
        rd(A_INIT, d); check("R2 R4 init read", d, 32'd1);
        check("R8 no latched key after release", {31'b0, access_en}, 32'd0);
        wr(A_INIT, 32'h0000_0000);
        check("R3 stays active after zero", {31'b0, active}, 32'd1);
        wr(A_INIT, 32'hFFFF_FFFF);
        rd(A_INIT, d); check("R4 upper bits read 0", d, 32'd1);
    endtask

    task automatic t_window_length();
        logic [31:0] d;
        int n;
        wr(A_KEY, 32'hFFFF_A965);
        check("R5 upper data ignored, window open", {31'b0, access_en}, 32'd1);
        rd(A_KEY, d); check("R10 key read while open", d, 32'h0001_0000);
        rd(A_OTHER, d); check("R11 other read while open", d, 32'd0);
        remaining(n);
        check("R6 window length", n, WIN);
        check("R6 closed after expiry", {31'b0, access_en}, 32'd0);
        rd(A_KEY, d); check("R10 key read closed", d, 32'd0);
        check("R3 still active", {31'b0, active}, 32'd1);
    endtask

    task automatic t_restart();
        int n;
        wr(A_KEY, 32'h0000_A965);
        idle(500);
        wr(A_KEY, 32'h0000_A965);
        remaining(n);
        check("R7 restarted window length", n, WIN);
    endtask

    task automatic t_wrong_key();
        int n;
        wr(A_KEY, 32'h0000_1234);
        check("R9 wrong key opens nothing", {31'b0, access_en}, 32'd0);
        wr(A_KEY, 32'h0000_A965);
        idle(10);
        wr(A_KEY, 32'h0000_A964);
        check("R9 wrong key keeps window", {31'b0, access_en}, 32'd1);
        remaining(n);
        check("R9 window not shortened or extended", n, WIN - 11);
    endtask

    initial begin
        idle(1);
        #1;
        t_reset_state();
        rst_n = 1'b1;
        idle(2);
        t_reset_state();
        t_key_before_release();
        t_bad_release();
        t_release();
        t_window_length();
        t_restart();
        t_wrong_key();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule